// File: doc/BRIEF.md
# Filter Security Fault Interrupt Controller

This block gathers access-violation events from up to four address filter units and turns them into sticky per-filter status, a single combined interrupt line, and a per-access bus response choice. Each filter presents one access per cycle. With the access come a permission-fail flag, computed upstream, and the vector of regions the access address hit. The block detects region overlap on its own from that vector. The access stream has no back-pressure: there is no ready signal, and every cycle in which an access valid bit is high is consumed. The response for that access appears combinationally in the same cycle.

Software programs a two-bit action setting through a small register write port. It reads the action setting and a status word, and clears per-filter status by writing ones to a clear word. The action setting decides two things independently. One bit enables the interrupt pin, and the other bit turns the response for a failing access from OKAY into a decode error. Status is recorded whatever the action setting is, so software can poll for faults even with the interrupt pin masked.

Top module: `fault_irq_ctrl`

## Requirements
- R1: `irq_o` is high exactly when action bit 1 is set and at least one implemented filter has its status bit set. It is a register output and follows a failure, a clear or an action write one cycle later.
- R2: For filter n, `resp_vld_o[n]` equals `acc_vld_i[n]`. `resp_err_o[n]` is high in the same cycle when that access fails and action bit 0 is set; otherwise the response is OKAY (`resp_err_o[n]` low).
- R3: A failure (permission or overlap) on filter n sets status bit n in the next cycle, for every action setting.
- R4: A failure on filter n while status bit n is already set sets the overrun flag of filter n, unless a clear of filter n arrives in the same cycle.
- R5: An access is an overlap when it hits two or more regions among regions 1 to NUM_REG-1. A hit on region 0 together with exactly one other region is not an overlap. An overlap sets both the status bit and the overlap flag of that filter.
- R6: A write with `wr_sel_i`=1 clears status, overrun and overlap of every filter n whose bit n of `wr_data_i` is 1. Zero bits leave their filters unchanged.
- R7: When a clear and a new failure for the same filter fall in one cycle, the status bit stays set. The overrun flag is cleared, and the overlap flag reflects only the new access.
- R8: The status word places status bits in 3:0, overrun flags in 11:8 and overlap flags in 19:16; all other bits read 0. Filters with index NUM_FILT or above always read 0, and their `resp_vld_o`/`resp_err_o` stay low.
- R9: After reset the action setting, the status word and `irq_o` are all zero.
- R10: A write with `wr_sel_i`=0 loads `wr_data_i[1:0]` into the action setting, visible on `act_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_vld_i | input | 4 | Per-filter access valid, one access per cycle |
| perm_fail_i | input | 4 | Per-filter permission failure for the current access |
| hit_i | input | 4*NUM_REG | Region hit vectors; filter n uses bits n*NUM_REG +: NUM_REG |
| resp_vld_o | output | 4 | Response valid, mirrors the access valid bits |
| resp_err_o | output | 4 | 1 = decode-error response, 0 = OKAY |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = action setting, 1 = clear word |
| wr_data_i | input | 32 | Register write data |
| act_o | output | 2 | Current action setting |
| status_o | output | 32 | Status word |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong status, overrun or overlap bit shows up on `status_o` one cycle after the access or write that caused it, and it stays visible there until software clears it. The interrupt pin, in contrast, hides every flag while action bit 1 is low, so the bench compares the whole status word after every cycle and does not rely on the pin. A wrong response choice is visible only in the cycle of the access itself, so the bench samples `resp_err_o` before the clock edge of each access.

// File: rtl/fault_irq_pkg.sv
`timescale 1ns/1ps
package fault_irq_pkg;
  localparam int MAX_FILT = 4;
  localparam int INT_LSB  = 0;
  localparam int OVR_LSB  = 8;
  localparam int OVL_LSB  = 16;
  localparam int WORD_W   = 32;

  typedef enum logic {
    SEL_ACTION = 1'b0,
    SEL_CLEAR  = 1'b1
  } wsel_e;

  typedef struct packed {
    logic irq_en;   // bit 1
    logic err_resp; // bit 0
  } action_t;
endpackage

// File: rtl/fault_ovl_detect.sv
`timescale 1ns/1ps
module fault_ovl_detect #(
  parameter int NUM_REG = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REG-1:0] hit_i,
  output logic               multi_o
);
  localparam int UP_W = NUM_REG - 1;

  logic [UP_W-1:0] upper;
  logic            unused_r0;

  assign upper     = hit_i[NUM_REG-1:1];
  assign unused_r0 = hit_i[0];
  // clearing the lowest set bit leaves something only if two or more were set
  assign multi_o   = |(upper & (upper - UP_W'(1)));

  AST_R0_ONLY_NO_OVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(upper) |-> !multi_o); // R5
  AST_TWO_HITS_OVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(upper) > 1) |-> multi_o); // R5
endmodule

// File: rtl/fault_filt_status.sv
`timescale 1ns/1ps
module fault_filt_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic ovl_i,
  input  logic clr_i,
  output logic int_o,
  output logic ovr_o,
  output logic ovl_o
);
  logic int_q, ovr_q, ovl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= 1'b0;
      ovr_q <= 1'b0;
      ovl_q <= 1'b0;
    end else begin
      int_q <= fail_i | (int_q & ~clr_i);
      if (clr_i) begin
        ovr_q <= 1'b0;
        ovl_q <= ovl_i;
      end else begin
        ovr_q <= ovr_q | (fail_i & int_q);
        ovl_q <= ovl_q | ovl_i;
      end
    end
  end

  assign int_o = int_q;
  assign ovr_o = ovr_q;
  assign ovl_o = ovl_q;

  AST_FAIL_SETS_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_i |=> int_q); // R3
  AST_SECOND_FAIL_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_i && int_q && !clr_i) |=> ovr_q); // R4
  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !fail_i) |=> (!int_q && !ovr_q && !ovl_q)); // R6
  AST_FAIL_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && fail_i) |=> (int_q && !ovr_q)); // R7
  AST_OVL_IMPLIES_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovl_q |-> int_q); // R5
endmodule

// File: rtl/fault_irq_ctrl.sv
`timescale 1ns/1ps
module fault_irq_ctrl
  import fault_irq_pkg::*;
#(
  parameter int NUM_FILT = 4,
  parameter int NUM_REG  = 9
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [MAX_FILT-1:0]          acc_vld_i,
  input  logic [MAX_FILT-1:0]          perm_fail_i,
  input  logic [MAX_FILT*NUM_REG-1:0]  hit_i,
  output logic [MAX_FILT-1:0]          resp_vld_o,
  output logic [MAX_FILT-1:0]          resp_err_o,
  input  logic                         wr_en_i,
  input  logic                         wr_sel_i,
  input  logic [WORD_W-1:0]            wr_data_i,
  output logic [1:0]                   act_o,
  output logic [WORD_W-1:0]            status_o,
  output logic                         irq_o
);
  action_t             act_q;
  logic                irq_q;
  logic [MAX_FILT-1:0] fail_vec, ovl_now, clr_vec;
  logic [MAX_FILT-1:0] int_vec, ovr_vec, ovl_vec;
  logic                int_any_next;
  logic                unused_wdata;

  assign unused_wdata = ^wr_data_i[WORD_W-1:MAX_FILT];

  always_comb begin
    clr_vec = '0;
    if (wr_en_i && wsel_e'(wr_sel_i) == SEL_CLEAR) clr_vec = wr_data_i[MAX_FILT-1:0];
  end

  for (genvar f = 0; f < MAX_FILT; f++) begin : g_filt
    if (f < NUM_FILT) begin : g_on
      logic multi;
      fault_ovl_detect #(.NUM_REG(NUM_REG)) u_ovl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hit_i   (hit_i[f*NUM_REG +: NUM_REG]),
        .multi_o (multi)
      );
      assign ovl_now[f]  = acc_vld_i[f] & multi;
      assign fail_vec[f] = acc_vld_i[f] & (perm_fail_i[f] | multi);
      assign resp_vld_o[f] = acc_vld_i[f];
      assign resp_err_o[f] = fail_vec[f] & act_q.err_resp;
      fault_filt_status u_st (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .fail_i (fail_vec[f]),
        .ovl_i  (ovl_now[f]),
        .clr_i  (clr_vec[f]),
        .int_o  (int_vec[f]),
        .ovr_o  (ovr_vec[f]),
        .ovl_o  (ovl_vec[f])
      );
    end else begin : g_off
      assign ovl_now[f]    = 1'b0;
      assign fail_vec[f]   = 1'b0;
      assign resp_vld_o[f] = 1'b0;
      assign resp_err_o[f] = 1'b0;
      assign int_vec[f]    = 1'b0;
      assign ovr_vec[f]    = 1'b0;
      assign ovl_vec[f]    = 1'b0;
    end
  end

  // next-cycle view of the combined status, so the pin lines up with the bits
  assign int_any_next = |(fail_vec | (int_vec & ~clr_vec));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_en_i && wsel_e'(wr_sel_i) == SEL_ACTION) begin
        act_q <= action_t'(wr_data_i[1:0]);
        irq_q <= wr_data_i[1] & int_any_next;
      end else begin
        irq_q <= act_q.irq_en & int_any_next;
      end
    end
  end

  always_comb begin
    status_o = '0;
    status_o[INT_LSB +: MAX_FILT] = int_vec;
    status_o[OVR_LSB +: MAX_FILT] = ovr_vec;
    status_o[OVL_LSB +: MAX_FILT] = ovl_vec;
  end

  assign act_o = act_q;
  assign irq_o = irq_q;

  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (act_q.irq_en && (int_vec != '0))); // R1
  AST_ERR_NEEDS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_err_o & ~resp_vld_o) == '0); // R2
  AST_ACT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> (act_o == $past(wr_data_i[1:0]))); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~32'h000F_0F0F) == '0); // R8
endmodule

// File: tb/fault_irq_ctrl_tb.sv
`timescale 1ns/1ps
module fault_irq_ctrl_tb;
  localparam int NF = 2;
  localparam int NR = 9;
  localparam int MF = 4;

  typedef struct {
    logic [31:0] st;
    logic        irq;
    logic [1:0]  act;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [MF-1:0] acc = '0, perm = '0;
  logic [MF*NR-1:0] hits = '0;
  logic [MF-1:0] rvld, rerr;
  logic we = 1'b0, ws = 1'b0;
  logic [31:0] wd = '0;
  logic [1:0] act;
  logic [31:0] st;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  exp_t q[$];
  logic [MF-1:0] m_int = '0, m_ovr = '0, m_ovl = '0;
  logic [1:0] m_act = '0;

  always #2 clk = ~clk;

  fault_irq_ctrl #(.NUM_FILT(NF), .NUM_REG(NR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_vld_i(acc), .perm_fail_i(perm), .hit_i(hits),
    .resp_vld_o(rvld), .resp_err_o(rerr), .wr_en_i(we), .wr_sel_i(ws), .wr_data_i(wd),
    .act_o(act), .status_o(st), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [MF*NR-1:0] hp(input int f, input logic [NR-1:0] m);
    return (MF*NR)'(m) << (f*NR);
  endfunction

  // driver: apply one cycle of stimulus, check the same-cycle response, queue the next state
  task automatic step(input logic [MF-1:0] a, input logic [MF-1:0] p, input logic [MF*NR-1:0] h,
                      input logic w, input logic s, input logic [31:0] d, input string tag);
    logic [MF-1:0] fl, ov, cl, e_err;
    exp_t e;
    @(negedge clk);
    acc = a; perm = p; hits = h; we = w; ws = s; wd = d;
    fl = '0; ov = '0; cl = '0;
    for (int f = 0; f < NF; f++) begin
      ov[f] = a[f] && ($countones(h[f*NR+1 +: NR-1]) >= 2);
      fl[f] = a[f] && (p[f] || ov[f]);
      cl[f] = w && s && d[f];
    end
    e_err = fl & {MF{m_act[0]}};
    #1;
    chk({tag, " R2 resp_vld"}, 32'(rvld), 32'(a & MF'((1 << NF) - 1)));
    chk({tag, " R2 resp_err"}, 32'(rerr), 32'(e_err));
    for (int f = 0; f < NF; f++) begin
      m_ovr[f] = cl[f] ? 1'b0 : (m_ovr[f] | (fl[f] & m_int[f]));
      m_ovl[f] = cl[f] ? ov[f] : (m_ovl[f] | ov[f]);
      m_int[f] = fl[f] | (m_int[f] & !cl[f]);
    end
    if (w && !s) m_act = d[1:0];
    e.st  = {12'h0, m_ovl, 4'h0, m_ovr, 4'h0, m_int};
    e.irq = m_act[1] && (m_int != '0);
    e.act = m_act;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare registered outputs just after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk({e.tag, " status"}, st, e.st);
        chk({e.tag, " R1 irq"}, 32'(irq), 32'(e.irq));
        chk({e.tag, " R10 act"}, 32'(act), 32'(e.act));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset status", st, 32'h0);
    chk("R9 reset irq", 32'(irq), 32'h0);
    chk("R9 reset act", 32'(act), 32'h0);
    step(4'b0001, 4'b0001, '0, 0, 0, 0, "R3 fail f0 masked");
    step(4'b0001, 4'b0001, '0, 0, 0, 0, "R4 second fail f0");
    step(4'b0000, 4'b0000, '0, 1, 1, 32'hFFFF_FFF0, "R6 zero bits no effect");
    step(4'b0000, 4'b0000, '0, 1, 1, 32'h1, "R6 clear f0");
    step(4'b0000, 4'b0000, '0, 1, 0, 32'h2, "R10 action irq on");
    step(4'b0010, 4'b0010, '0, 0, 0, 0, "R1 fail f1 irq");
    step(4'b0000, 4'b0000, '0, 1, 0, 32'h3, "R10 action both");
    step(4'b0001, 4'b0001, '0, 0, 0, 0, "R2 decerr f0");
    step(4'b0011, 4'b0000, '0, 0, 0, 0, "R2 clean access");
    step(4'b0000, 4'b0000, '0, 1, 1, 32'h3, "R6 clear both");
    step(4'b0001, 4'b0000, hp(0, 9'b000001001), 0, 0, 0, "R5 region0 plus one");
    step(4'b0010, 4'b0000, hp(1, 9'b000100100), 0, 0, 0, "R5 overlap f1");
    step(4'b0001, 4'b0000, hp(0, 9'b100000001) | hp(1, 9'b000000011), 0, 0, 0, "R5 single hits");
    step(4'b0010, 4'b0010, '0, 1, 1, 32'h2, "R7 clear and fail f1");
    step(4'b0001, 4'b0000, hp(0, 9'b110000000), 1, 1, 32'h1, "R7 clear and overlap f0");
    step(4'b1100, 4'b1100, hp(2, 9'b000000110), 0, 0, 0, "R8 unimplemented filters");
    step(4'b0000, 4'b0000, '0, 1, 0, 32'h1, "R1 irq masked by action");
    step(4'b0000, 4'b0000, '0, 1, 1, 32'hF, "R6 clear all");
    @(negedge clk);
    acc = '0; perm = '0; hits = '0; we = 1'b0;
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule